// File: doc/BRIEF.md
# Iterative SHA-256/224 Compression Core

This block performs the SHA-2 compression function on one 512-bit message block at a time. It computes one round per clock and keeps the 64-entry message schedule as a 16-word sliding window, so it never stores more than 16 schedule words. A one-cycle `start_msg` pulse begins a new message. The pulse loads the initial hash values for the selected variant (SHA-256, or SHA-224 when `mode_224` is high). A one-cycle `chain_blk` pulse compresses a further block onto the hash state the core already holds.

When the rounds finish, the working variables are added into eight 32-bit hash registers. At that point `ready` returns high and `digest_valid` is raised. A saved intermediate hash can be written back through `restore_en`/`restore_state` while the core is idle. A later `chain_blk` then resumes the message from that state. Padding, message-length tracking and bus access belong to the surrounding logic.

Top module: `sha2_iter_core`

## Requirements
- R1: After the asynchronous active-low reset, `ready` is 1, `digest_valid` is 0 and `digest` is all zeros.
- R2: With `mode_224`=0, a `start_msg` pulse on the padded one-block message "abc" produces digest BA7816BF8F01CFEA414140DE5DAE2223B00361A396177A9CB410FF61F20015AD. Block bits 511:480 form schedule word 0, and `digest` is {H0..H7} with H0 in bits 255:224.
- R3: With `mode_224`=1, the same message produces 23097D223405D8228642A477BDA255B32AADBCE4BDA0B3F7E36C9DA7 in `digest[255:32]`. Bits 31:0 are not part of the result.
- R4: A `chain_blk` pulse adds the compression of the new block onto the current hash registers, so two chained blocks give the two-block message digest.
- R5: A `restore_en` pulse while idle, with `start_msg` and `chain_blk` low, loads `restore_state` into the hash registers, which appear on `digest` at the next cycle. A following `chain_blk` continues from that state.
- R6: `ready` falls on the clock edge that accepts `start_msg` or `chain_blk`. It stays low for exactly 65 cycles: 64 rounds followed by one fold cycle.
- R7: `digest_valid` rises together with `ready` at the end of an operation. It is cleared by an accepted `start_msg`, `chain_blk` or `restore_en`.
- R8: `start_msg`, `chain_blk` and `restore_en` pulses that arrive while `ready` is low have no effect on the operation in progress or on its result.
- R9: While idle with no command asserted, `digest` and `digest_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_msg | input | 1 | Begin a new message from the variant's initial hash |
| chain_blk | input | 1 | Compress a block onto the current hash |
| mode_224 | input | 1 | 1 selects SHA-224 initial values, 0 selects SHA-256 |
| restore_en | input | 1 | Load `restore_state` into the hash registers when idle |
| restore_state | input | 256 | Saved intermediate hash, H0 in the top word |
| block | input | 512 | Message block, word 0 in the top 32 bits |
| ready | output | 1 | High when idle and able to accept a command |
| digest_valid | output | 1 | High when `digest` holds a completed result |
| digest | output | 256 | Hash registers {H0..H7} |

## Verification
The core has no parameters, because the word size, round count and window depth are fixed by the algorithm, so the bench builds the one configuration and that covers every path. The scoreboard pairs each accepted command with a digest known from published vectors or from an independent behavioural compression model. It also times each busy period at exactly 65 cycles. Restore, chaining after both variants, and commands issued during a busy period are all exercised against that one build.

// File: rtl/sha2_iter_core.sv
module sha2_iter_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_msg,
  input  logic         chain_blk,
  input  logic         mode_224,
  input  logic         restore_en,
  input  logic [255:0] restore_state,
  input  logic [511:0] block,
  output logic         ready,
  output logic         digest_valid,
  output logic [255:0] digest
);

  localparam int NW   = 8;
  localparam int WIN  = 16;
  localparam int LAST = 63;

  typedef enum logic [1:0] {PH_IDLE, PH_ROUND, PH_FOLD} phase_t;

  localparam logic [31:0] KTAB [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  localparam logic [255:0] IV_256 =
    256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;
  localparam logic [255:0] IV_224 =
    256'hc1059ed8_367cd507_3070dd17_f70e5939_ffc00b31_68581511_64f98fa7_befa4fa4;

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  phase_t      phase;
  logic [5:0]  rnd;
  logic [31:0] hreg [NW];
  logic [31:0] wv   [NW];
  logic [31:0] win  [WIN];
  logic        done_q;

  logic [31:0] w_next, w_cur, t1, t2, ch, maj, s1, s0;
  logic [255:0] iv_sel;
  logic        take, take_rst;

  assign ready        = (phase == PH_IDLE);
  assign digest_valid = done_q;
  assign digest       = {hreg[0], hreg[1], hreg[2], hreg[3], hreg[4], hreg[5], hreg[6], hreg[7]};
  assign iv_sel       = mode_224 ? IV_224 : IV_256;
  assign take         = ready && (start_msg || chain_blk);
  assign take_rst     = ready && restore_en && !start_msg && !chain_blk;

  assign w_next = (rotr(win[14], 17) ^ rotr(win[14], 19) ^ (win[14] >> 10)) + win[9] +
                  (rotr(win[1], 7) ^ rotr(win[1], 18) ^ (win[1] >> 3)) + win[0];
  assign w_cur  = (rnd < 6'd16) ? win[rnd[3:0]] : w_next;

  assign s1  = rotr(wv[4], 6) ^ rotr(wv[4], 11) ^ rotr(wv[4], 25);
  assign s0  = rotr(wv[0], 2) ^ rotr(wv[0], 13) ^ rotr(wv[0], 22);
  assign ch  = (wv[4] & wv[5]) ^ (~wv[4] & wv[6]);
  assign maj = (wv[0] & wv[1]) ^ (wv[0] & wv[2]) ^ (wv[1] & wv[2]);
  assign t1  = wv[7] + s1 + ch + KTAB[rnd] + w_cur;
  assign t2  = s0 + maj;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      rnd    <= '0;
      done_q <= 1'b0;
      for (int i = 0; i < NW; i++) begin
        hreg[i] <= '0;
        wv[i]   <= '0;
      end
      for (int i = 0; i < WIN; i++) win[i] <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (take) begin
            for (int i = 0; i < WIN; i++) win[i] <= block[511 - 32*i -: 32];
            rnd    <= '0;
            done_q <= 1'b0;
            phase  <= PH_ROUND;
            for (int i = 0; i < NW; i++) begin
              if (start_msg) begin
                hreg[i] <= iv_sel[255 - 32*i -: 32];
                wv[i]   <= iv_sel[255 - 32*i -: 32];
              end else begin
                wv[i]   <= hreg[i];
              end
            end
          end else if (take_rst) begin
            done_q <= 1'b0;
            for (int i = 0; i < NW; i++) hreg[i] <= restore_state[255 - 32*i -: 32];
          end
        end
        PH_ROUND: begin
          wv[0] <= t1 + t2;
          wv[1] <= wv[0];
          wv[2] <= wv[1];
          wv[3] <= wv[2];
          wv[4] <= wv[3] + t1;
          wv[5] <= wv[4];
          wv[6] <= wv[5];
          wv[7] <= wv[6];
          if (rnd > 6'd15) begin
            for (int i = 0; i < WIN - 1; i++) win[i] <= win[i+1];
            win[WIN-1] <= w_next;
          end
          rnd <= rnd + 6'd1;
          if (rnd == 6'(LAST)) phase <= PH_FOLD;
        end
        PH_FOLD: begin
          for (int i = 0; i < NW; i++) hreg[i] <= hreg[i] + wv[i];
          done_q <= 1'b1;
          phase  <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ready && (start_msg || chain_blk) |=> !ready && !digest_valid); // R6
  AST_ROUNDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ROUND && rnd != 6'(LAST)) |=> !ready); // R6
  AST_FOLD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FOLD) |=> ready && digest_valid); // R7
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ROUND && rnd != 6'(LAST) && (start_msg || chain_blk)) |=> rnd != 6'd0); // R8
  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ready && restore_en && !start_msg && !chain_blk |=> digest == $past(restore_state) && !digest_valid); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !start_msg && !chain_blk && !restore_en |=> $stable(digest) && $stable(digest_valid)); // R9

endmodule

// File: tb/sha2_iter_core_tb_top.sv
module sha2_iter_core_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_msg, chain_blk, mode_224, restore_en;
  logic [255:0] restore_state;
  logic [511:0] block;
  logic         ready, digest_valid;
  logic [255:0] digest;

  int checks = 0;
  int failures = 0;

  logic [255:0] exp_q [$];
  logic [255:0] mask_q [$];
  string        tag_q [$];
  int           busy_cnt = 0;
  logic         prev_ready = 1'b1;

  localparam logic [255:0] IV256 =
    256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;
  localparam logic [511:0] ABC_BLK = {32'h61626380, 448'h0, 32'h00000018};
  localparam logic [511:0] TWO_B1 = {
    32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667, 32'h65666768, 32'h66676869,
    32'h6768696a, 32'h68696a6b, 32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
    32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
  localparam logic [511:0] TWO_B2 = {480'h0, 32'h000001c0};
  localparam logic [255:0] MID_STATE =
    256'h85e655d6_417a1795_3363376a_624cde5c_76e09589_cac5f811_cc4b32c1_f20e533a;
  localparam logic [255:0] TWO_DIG =
    256'h248D6A61D20638B8E5C026930C3E6039A33CE45964FF2167F6ECEDD419DB06C1;
  localparam logic [255:0] ABC256 =
    256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
  localparam logic [255:0] ABC224 =
    {224'h23097d223405d8228642a477bda255b32aadbce4bda0b3f7e36c9da7, 32'h0};
  localparam logic [255:0] FULL = {256{1'b1}};
  localparam logic [255:0] M224 = {{224{1'b1}}, 32'h0};

  localparam logic [31:0] KREF [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_compress(input logic [255:0] h, input logic [511:0] b);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] x1, x2;
    logic [255:0] r;
    for (int t = 0; t < 16; t++) w[t] = b[511 - 32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7] +
             (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
    for (int i = 0; i < 8; i++) v[i] = h[255 - 32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      x1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25)) +
           ((v[4] & v[5]) ^ (~v[4] & v[6])) + KREF[t] + w[t];
      x2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22)) +
           ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      for (int i = 7; i > 0; i--) v[i] = v[i-1];
      v[4] = v[4] + x1;
      v[0] = x1 + x2;
    end
    for (int i = 0; i < 8; i++) r[255 - 32*i -: 32] = h[255 - 32*i -: 32] + v[i];
    return r;
  endfunction

  sha2_iter_core dut_i (
    .clk(clk), .rst_n(rst_n), .start_msg(start_msg), .chain_blk(chain_blk),
    .mode_224(mode_224), .restore_en(restore_en), .restore_state(restore_state),
    .block(block), .ready(ready), .digest_valid(digest_valid), .digest(digest));

  always #5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ready) busy_cnt++;
      else if (!prev_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected completion", digest, '0);
        end else begin
          logic [255:0] e, m;
          string tg;
          e = exp_q.pop_front(); m = mask_q.pop_front(); tg = tag_q.pop_front();
          chk((digest & m) == (e & m), tg, digest & m, e & m);
          chk(digest_valid == 1'b1, "R7 valid at completion", 256'(digest_valid), 256'd1);
          chk(busy_cnt == 65, "R6 busy length", 256'(busy_cnt), 256'd65);
        end
        busy_cnt = 0;
      end
      prev_ready = ready;
    end
  end

  task automatic run_op(input logic is_new, input logic m224, input logic [511:0] b,
                        input logic [255:0] e, input logic [255:0] m, input string tg);
    exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(tg);
    @(negedge clk);
    block = b; mode_224 = m224; start_msg = is_new; chain_blk = !is_new;
    @(negedge clk);
    start_msg = 1'b0; chain_blk = 1'b0;
    chk(ready == 1'b0 && digest_valid == 1'b0, "R6 R7 accept drops ready and valid",
        256'({ready, digest_valid}), 256'd0);
    while (!ready) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL R6 watchdog act=hung exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [255:0] h1, hold;
    logic [511:0] blk_c;
    rst_n = 1'b0; start_msg = 0; chain_blk = 0; mode_224 = 0; restore_en = 0;
    restore_state = '0; block = '0;
    #23;
    chk(ready == 1'b1, "R1 ready in reset", 256'(ready), 256'd1);
    chk(digest_valid == 1'b0, "R1 valid in reset", 256'(digest_valid), 256'd0);
    chk(digest == '0, "R1 digest in reset", digest, '0);
    rst_n = 1'b1;

    run_op(1'b1, 1'b0, ABC_BLK, ABC256, FULL, "R2 abc sha256");
    run_op(1'b1, 1'b1, ABC_BLK, ABC224, M224, "R3 abc sha224");

    run_op(1'b1, 1'b0, TWO_B1, MID_STATE, FULL, "R4 two-block first");
    run_op(1'b0, 1'b0, TWO_B2, TWO_DIG, FULL, "R4 two-block chained");

    blk_c = {16{32'h5a3c96e1}} ^ {TWO_B1[255:0], ABC_BLK[511:256]};
    run_op(1'b0, 1'b0, blk_c, ref_compress(TWO_DIG, blk_c), FULL, "R4 chain onto previous");

    hold = digest;
    repeat (20) @(negedge clk);
    chk(digest == hold, "R9 idle hold digest", digest, hold);
    chk(digest_valid == 1'b1, "R9 idle hold valid", 256'(digest_valid), 256'd1);

    @(negedge clk);
    restore_en = 1'b1; restore_state = MID_STATE;
    @(negedge clk);
    restore_en = 1'b0; restore_state = '0;
    chk(digest == MID_STATE, "R5 restore load", digest, MID_STATE);
    chk(digest_valid == 1'b0, "R7 restore clears valid", 256'(digest_valid), 256'd0);
    run_op(1'b0, 1'b0, TWO_B2, TWO_DIG, FULL, "R5 resume after restore");

    h1 = ref_compress(IV256, blk_c);
    exp_q.push_back(h1); mask_q.push_back(FULL); tag_q.push_back("R8 busy commands ignored");
    @(negedge clk);
    block = blk_c; mode_224 = 1'b0; start_msg = 1'b1;
    @(negedge clk);
    start_msg = 1'b0;
    repeat (10) @(negedge clk);
    block = ABC_BLK; mode_224 = 1'b1; start_msg = 1'b1; chain_blk = 1'b1;
    restore_en = 1'b1; restore_state = {8{32'hdeadbeef}};
    @(negedge clk);
    start_msg = 1'b0; chain_blk = 1'b0; restore_en = 1'b0;
    chk(ready == 1'b0, "R8 still busy after stray pulse", 256'(ready), 256'd0);
    while (!ready) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(digest == h1, "R8 result untouched", digest, h1);

    run_op(1'b1, 1'b1, TWO_B1, ref_compress({32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
            32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4}, TWO_B1), M224, "R3 sha224 other block");

    @(negedge clk);
    chk(exp_q.size() == 0, "R6 all results seen", 256'(exp_q.size()), 256'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule